// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Lane

This block is one lane of a vector multiply unit. It treats its two 16-bit inputs as signed Q15 fractions, forms their product, doubles it so the binary point lines up with the operands, and either loads that value into a 48-bit accumulator or adds it to what the accumulator already holds. The accumulator is kept as three 16-bit slices: low, middle and high. The high slice acts as guard bits, so long chains of accumulations do not wrap.

Each accepted operation also produces a 16-bit result taken from the upper 32 bits of the new accumulator value. The opcode selects how that result is saturated: a signed clamp to the Q15 range, or an unsigned clamp to 0..0xFFFF. The load forms add a rounding term of one half LSB of the middle slice. The accumulate forms add no rounding term. The accumulator and the result are registered together on the clock edge that accepts an operation. A lane of a wider vector unit is built by placing several copies of this block side by side.

Top module: `fracmac_lane`

## Requirements
- R1: When the synchronous active-low reset is applied, all three accumulator slices and the result read zero on the next edge. The valid strobe has no effect while reset is low.
- R2: On an edge where valid is low, the accumulator slices and the result keep their values, whatever the operands and opcode are.
- R3: The opcode is encoded as follows: bit 1 = 1 selects accumulate and 0 selects load; bit 0 = 1 selects unsigned readout and 0 selects signed readout. A load form sets the 48-bit accumulator to the sign-extended value 2·a·b + 0x8000, with the low slice in bits 15:0, the middle slice in bits 31:16 and the high slice in bits 47:32.
- R4: After a load form, the high slice is 0xFFFF when the rounded value is negative and 0x0000 otherwise.
- R5: Loading with a = b = 0x8000 gives an accumulator of 0x0000_8000_8000, which is positive. The signed readout is then 0x7FFF and the unsigned readout is 0xFFFF.
- R6: An accumulate form adds the sign-extended value 2·a·b, with no rounding term, to the 48-bit accumulator modulo 2^48. Carries pass from the low slice into the middle slice, and from the middle slice into the high slice.
- R7: Signed readout treats accumulator bits 47:16 as a signed value V. The result is 0x7FFF when V > 32767, 0x8000 when V < -32768, and bits 31:16 otherwise.
- R8: Unsigned readout uses the same V. The result is 0xFFFF when V > 32767, 0x0000 when V < 0, and bits 31:16 otherwise. In particular, a negative load result reads as 0x0000.
- R9: The result is registered on the same edge as the accumulator update, and it is computed from the updated accumulator value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Accept an operation on this edge |
| op_i | input | 2 | Opcode: bit 1 selects accumulate, bit 0 selects unsigned readout |
| a_i | input | 16 | Signed Q15 operand |
| b_i | input | 16 | Signed Q15 operand |
| result_o | output | 16 | Saturated readout (registered) |
| acc_lo_o | output | 16 | Accumulator bits 15:0 |
| acc_mid_o | output | 16 | Accumulator bits 31:16 |
| acc_hi_o | output | 16 | Accumulator bits 47:32 |

## Verification
The assertions check, on every cycle, properties that hold for any operands:
- the hold behaviour when valid is low;
- the high slice being a pure sign fill after a load;
- the parity of the low slice, which every doubled product leaves unchanged;
- the fixed outcome of the most-negative-squared corner;
- the shape of both readouts (a pass-through whenever the high slice is a sign fill, a clamp value otherwise, and no unsigned result in 0x8000..0xFFFE).

Only the bench's scenarios can show that the arithmetic itself is exact. These include carry propagation across slices in long random accumulate chains, saturation reached by repeated accumulation in both directions, and mixed opcode sequences. The bench checks each of these against a 64-bit integer model on every clock.

// File: rtl/fracmac_pkg.sv
// Package: shared opcode type and helpers for the fractional MAC lane.
// Assumes a 2-bit opcode: bit 1 = accumulate, bit 0 = unsigned readout.
package fracmac_pkg;

    typedef enum logic [1:0] {
        OP_LOAD_S  = 2'b00,
        OP_LOAD_U  = 2'b01,
        OP_ACCUM_S = 2'b10,
        OP_ACCUM_U = 2'b11
    } fm_op_e;

    // True when the opcode adds into the accumulator instead of loading it
    function automatic logic op_accumulates(input logic [1:0] op);
        return op[1];
    endfunction

    // True when the opcode reads out with the unsigned clamp
    function automatic logic op_unsigned(input logic [1:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/fracmac_product.sv
// Module: fracmac_product
// Forms the signed DW x DW product, doubles it (Q15 alignment) and
// sign-extends it to the accumulator width. Purely combinational.
// Assumes AW > 2*DW so the doubled product (2*DW+1 bits) always fits.
module fracmac_product #(
    parameter int DW = 16,
    parameter int AW = 48
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [AW-1:0] addend_o
);
    localparam int PW  = 2 * DW;
    localparam int EXT = AW - PW - 1;

    logic signed [PW-1:0] prod;

    // Signed multiply; the most-negative square still fits in PW bits
    always_comb begin
        prod = $signed(a_i) * $signed(b_i);
    end

    // Double by appending a zero and widen with the product's sign
    always_comb begin
        addend_o = {{EXT{prod[PW-1]}}, prod, 1'b0};
    end

endmodule

// File: rtl/fracmac_accum.sv
// Module: fracmac_accum
// Computes the next accumulator value as a chain of DW-bit slices with
// explicit carries. The base is either the current accumulator or the
// rounding constant (half an LSB of the middle slice).
// Assumes AW is a whole multiple of DW.
module fracmac_accum #(
    parameter int DW = 16,
    parameter int AW = 48
) (
    input  logic [AW-1:0] acc_q_i,
    input  logic [AW-1:0] addend_i,
    input  logic          accumulate_i,
    output logic [AW-1:0] acc_next_o
);
    localparam int NSL = AW / DW;
    localparam logic [AW-1:0] ROUND_K = AW'(1) << (DW - 1);

    logic [AW-1:0]  base;
    logic [NSL-1:0] carry;

    // Choose between the running sum and the rounding constant
    always_comb begin
        base = accumulate_i ? acc_q_i : ROUND_K;
    end

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < NSL; g++) begin : g_slice
        if (g < NSL - 1) begin : g_mid
            logic [DW:0] sum;
            // Slice add producing a carry into the next slice
            always_comb begin
                sum = {1'b0, base[g*DW +: DW]} + {1'b0, addend_i[g*DW +: DW]}
                    + {{DW{1'b0}}, carry[g]};
            end
            assign carry[g+1]              = sum[DW];
            assign acc_next_o[g*DW +: DW]  = sum[DW-1:0];
        end else begin : g_top
            logic [DW-1:0] sum;
            // Top slice wraps modulo 2^AW, carry-out discarded
            always_comb begin
                sum = base[g*DW +: DW] + addend_i[g*DW +: DW]
                    + {{(DW-1){1'b0}}, carry[g]};
            end
            assign acc_next_o[g*DW +: DW] = sum;
        end
    end

endmodule

// File: rtl/fracmac_sat.sv
// Module: fracmac_sat
// Reads a DW-bit result from accumulator bits AW-1:DW treated as signed V.
// Signed mode clamps to the Q15 range; unsigned mode clamps to 0..2^DW-1.
// Combinational; assumes AW >= 3*DW.
module fracmac_sat #(
    parameter int DW = 16,
    parameter int AW = 48
) (
    input  logic [AW-1:0] acc_i,
    input  logic          unsigned_i,
    output logic [DW-1:0] result_o
);
    localparam int HW = AW - DW;
    localparam logic signed [HW-1:0] POS_MAX = HW'((64'd1 << (DW - 1)) - 64'd1);
    localparam logic signed [HW-1:0] NEG_MIN = -POS_MAX - HW'(1);
    localparam logic [DW-1:0] S_HI = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] S_LO = {1'b1, {(DW-1){1'b0}}};

    logic signed [HW-1:0] upper;
    logic [DW-1:0]        mid;
    logic                 over, under, neg;
    logic [DW-1:0]        sat_s, sat_u;

    // Split the accumulator into the compared value and the raw middle
    always_comb begin
        upper = $signed(acc_i[AW-1:DW]);
        mid   = acc_i[2*DW-1:DW];
    end

    // Range flags of V
    always_comb begin
        over  = upper > POS_MAX;
        under = upper < NEG_MIN;
        neg   = upper[HW-1];
    end

    // Signed clamp
    always_comb begin
        if (over)       sat_s = S_HI;
        else if (under) sat_s = S_LO;
        else            sat_s = mid;
    end

    // Unsigned clamp: positive overflow to all ones, any negative to zero
    always_comb begin
        if (over)     sat_u = '1;
        else if (neg) sat_u = '0;
        else          sat_u = mid;
    end

    // Mode select
    always_comb begin
        result_o = unsigned_i ? sat_u : sat_s;
    end

endmodule

// File: rtl/fracmac_lane.sv
// Module: fracmac_lane (top)
// One lane of a Q15 fractional multiply / multiply-accumulate unit with a
// 48-bit accumulator in three slices and a registered saturated readout.
// Assumes one operation per accepted edge; no back-pressure.
module fracmac_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [1:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] result_o,
    output logic [DW-1:0] acc_lo_o,
    output logic [DW-1:0] acc_mid_o,
    output logic [DW-1:0] acc_hi_o
);
    import fracmac_pkg::*;

    localparam int NSL = 3;
    localparam int AW  = NSL * DW;

    logic [AW-1:0] acc_q, acc_next, addend;
    logic [DW-1:0] res_q, res_next;

    fracmac_product #(.DW(DW), .AW(AW)) u_prod (
        .a_i      (a_i),
        .b_i      (b_i),
        .addend_o (addend)
    );

    fracmac_accum #(.DW(DW), .AW(AW)) u_accum (
        .acc_q_i      (acc_q),
        .addend_i     (addend),
        .accumulate_i (op_accumulates(op_i)),
        .acc_next_o   (acc_next)
    );

    fracmac_sat #(.DW(DW), .AW(AW)) u_sat (
        .acc_i      (acc_next),
        .unsigned_i (op_unsigned(op_i)),
        .result_o   (res_next)
    );

    // State register: accumulator and readout update together on valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else if (valid_i) begin
            acc_q <= acc_next;
            res_q <= res_next;
        end
    end

    assign result_o  = res_q;
    assign acc_lo_o  = acc_q[DW-1:0];
    assign acc_mid_o = acc_q[2*DW-1:DW];
    assign acc_hi_o  = acc_q[AW-1:2*DW];

endmodule

// File: rtl/fracmac_lane_chk.sv
// Module: fracmac_lane_chk
// Port-level properties of the lane, attached by bind below.
module fracmac_lane_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic [1:0]    op_i,
    input logic [DW-1:0] a_i,
    input logic [DW-1:0] b_i,
    input logic [DW-1:0] result_o,
    input logic [DW-1:0] acc_lo_o,
    input logic [DW-1:0] acc_mid_o,
    input logic [DW-1:0] acc_hi_o
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};

    // R2: idle edges change nothing
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(result_o) && $stable(acc_lo_o)
                      && $stable(acc_mid_o) && $stable(acc_hi_o)));

    // R3: a load leaves bit 0 of the low slice clear (even product + 0x8000)
    p_load_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[1]) |=> (acc_lo_o[0] == 1'b0));

    // R4: a load leaves the high slice as a pure sign fill
    p_hi_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[1]) |=> (acc_hi_o == '0 || acc_hi_o == '1));

    // R5: most-negative squared
    p_corner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[1] && a_i == MOST_NEG && b_i == MOST_NEG) |=>
        (acc_hi_o == '0 && acc_mid_o == MOST_NEG && acc_lo_o == MOST_NEG
         && result_o == ($past(op_i[0]) ? '1 : MOST_POS)));

    // R6: accumulating an even addend keeps the low-slice parity
    p_accum_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[1]) |=> (acc_lo_o[0] == $past(acc_lo_o[0])));

    // R7: signed readout passes the middle when in range, else a clamp value
    p_signed_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i[0]) |=>
        ((acc_hi_o == {DW{acc_mid_o[DW-1]}}) ? (result_o == acc_mid_o)
            : (result_o == MOST_POS || result_o == MOST_NEG)));

    // R8: unsigned readout never lands in MOST_NEG..all-ones-minus-one
    p_unsigned_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[0]) |=> (!result_o[DW-1] || result_o == '1));

    // R8: unsigned readout passes small non-negative values through
    p_unsigned_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[0]) |=>
        ((acc_hi_o == '0 && !acc_mid_o[DW-1]) ? (result_o == acc_mid_o) : 1'b1));

    // Keeps b_i referenced for the corner property's operand pair
    logic unused_ok;
    assign unused_ok = ^b_i;

endmodule

bind fracmac_lane fracmac_lane_chk #(.DW(DW)) chk_i (.*);

// File: tb/fracmac_lane_tb.sv
`timescale 1ns/1ps
module fracmac_lane_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [15:0] a_i = '0, b_i = '0;
    logic [15:0] result_o, acc_lo_o, acc_mid_o, acc_hi_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    // reference state
    logic [47:0] m_acc = '0;
    logic [15:0] m_res = '0;

    always #2 clk = ~clk;

    fracmac_lane #(.DW(16)) dut_i (
        .clk, .rst_n, .valid_i, .op_i, .a_i, .b_i,
        .result_o, .acc_lo_o, .acc_mid_o, .acc_hi_o
    );

    function automatic logic [15:0] model_read(input logic [47:0] acc, input bit uns);
        longint v;
        v = longint'($signed(acc[47:16]));
        if (uns) begin
            if (v > 32767) return 16'hFFFF;
            if (v < 0)     return 16'h0000;
            return acc[31:16];
        end
        if (v > 32767)  return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return acc[31:16];
    endfunction

    task automatic compare(input string tag);
        n_tests++;
        if ({result_o, acc_hi_o, acc_mid_o, acc_lo_o} !== {m_res, m_acc}) begin
            n_fail++;
            $display("FAIL %s: got res=%h acc=%h_%h_%h exp res=%h acc=%h",
                     tag, result_o, acc_hi_o, acc_mid_o, acc_lo_o, m_res, m_acc);
        end
    endtask

    // Drive one cycle at a negedge, update the model, compare after the edge
    task automatic step(input bit v, input logic [1:0] op, input logic [15:0] a,
                        input logic [15:0] b, input string tag);
        longint p;
        valid_i = v; op_i = op; a_i = a; b_i = b;
        if (v && rst_n) begin
            p = longint'($signed(a)) * longint'($signed(b)) * 2;
            if (op[1]) m_acc = m_acc + 48'(p);
            else       m_acc = 48'(p + 32768);
            m_res = model_read(m_acc, op[0]);
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, got hung exp done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: valid pulses during reset leave everything zero
        step(1'b1, 2'b10, 16'h4000, 16'h4000, "R1 reset");
        step(1'b1, 2'b00, 16'h1234, 16'h7777, "R1 reset");
        rst_n = 1'b1;

        // R3 / R4 / R7: signed loads, fixed then random
        step(1'b1, 2'b00, 16'h4000, 16'h4000, "R3 load 0.25");
        step(1'b1, 2'b00, 16'hC000, 16'h4000, "R4 load negative");
        step(1'b1, 2'b00, 16'h0000, 16'h1234, "R4 load zero");
        for (int i = 0; i < 300; i++)
            step(1'b1, 2'b00, 16'($urandom), 16'($urandom), "R7 random load signed");

        // R8: unsigned loads, negative product reads zero
        step(1'b1, 2'b01, 16'h8001, 16'h7FFF, "R8 negative unsigned");
        for (int i = 0; i < 300; i++)
            step(1'b1, 2'b01, 16'($urandom), 16'($urandom), "R8 random load unsigned");

        // R5: most-negative squared in both modes
        step(1'b1, 2'b00, 16'h8000, 16'h8000, "R5 corner signed");
        step(1'b1, 2'b01, 16'h8000, 16'h8000, "R5 corner unsigned");

        // R2: idle cycles with busy inputs
        for (int i = 0; i < 20; i++)
            step(1'b0, 2'($urandom), 16'($urandom), 16'($urandom), "R2 hold");

        // R6: random signed accumulate chain
        step(1'b1, 2'b00, 16'h0000, 16'h0000, "R6 chain start");
        for (int i = 0; i < 400; i++)
            step(1'b1, 2'b10, 16'($urandom), 16'($urandom), "R6 random accumulate");

        // R7: positive saturation by repetition
        step(1'b1, 2'b00, 16'h7FFF, 16'h7FFF, "R7 seed");
        for (int i = 0; i < 8; i++)
            step(1'b1, 2'b10, 16'h7FFF, 16'h7FFF, "R7 saturate high");
        // R7: negative saturation
        step(1'b1, 2'b00, 16'h8000, 16'h7FFF, "R7 seed negative");
        for (int i = 0; i < 8; i++)
            step(1'b1, 2'b10, 16'h8000, 16'h7FFF, "R7 saturate low");

        // R8: unsigned chain falling below zero and rising above max
        step(1'b1, 2'b01, 16'h0100, 16'h0100, "R8 seed");
        for (int i = 0; i < 6; i++)
            step(1'b1, 2'b11, 16'h8000, 16'h7FFF, "R8 accumulate below zero");
        for (int i = 0; i < 20; i++)
            step(1'b1, 2'b11, 16'h8000, 16'h8000, "R8 accumulate above max");

        // R6: carries into the high slice from repeated corner squares
        step(1'b1, 2'b00, 16'h0000, 16'h0000, "R6 carry seed");
        for (int i = 0; i < 70; i++)
            step(1'b1, 2'b10, 16'h8000, 16'h8000, "R6 carry to high slice");

        // R9: mixed opcodes with random valid
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 3) != 0), 2'($urandom), 16'($urandom),
                 16'($urandom), "R9 mixed");

        // R1: reset mid-run clears state
        rst_n = 1'b0;
        m_acc = '0; m_res = '0;
        step(1'b1, 2'b10, 16'h7FFF, 16'h7FFF, "R1 reset again");
        rst_n = 1'b1;
        step(1'b0, 2'b00, 16'h0000, 16'h0000, "R1 after reset");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule